// File: doc/BRIEF.md
# Shutdown and Wake-up Controller

This block is an always-on power sequencer that runs from a slow clock. Software removes system power by writing a shutdown command to the control register. The command carries a password byte. The controller then holds the power-enable output low until a qualified wake-up event arrives.

Three sources can end a shutdown:
- an external wake pin, with a selectable sensitivity and a programmable debounce count;
- a request from a real-time timer, gated by its own enable bit;
- a request from a real-time clock, gated by its own enable bit.

Each source that causes a wake is latched into a status word. Software reads that word after power returns to learn the cause, and the read clears it.

The control logic is a two-state machine:
- **ST_ON**: power is applied. The exit is **T_SHUTDOWN**, taken on a control write with the correct key and the command bit set.
- **ST_OFF**: power is removed. The exit is **T_WAKE**, taken when the debounced pin condition or an enabled timer or clock request is present.

Register access uses a plain single-cycle port. A write takes effect on the clock edge. Read data is combinational in the same cycle as the read strobe.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset, `pwr_en` is 1, the mode register (offset 0x4) reads 0 and the status register (offset 0x8) reads 0.
- R2: In ST_ON, a write to offset 0x0 with wdata[0]=1 and wdata[31:24]=0xA5 drives `pwr_en` low from the next clock edge. A write with any other key, or with wdata[0]=0, leaves `pwr_en` high. Offset 0x0 reads as 0.
- R3: The mode register keeps only bits 2:0 (pin mode), 7:4 (debounce count N), 16 (timer enable) and 17 (clock enable). All other bits read 0, so writing all ones reads back 0x000300F7.
- R4: With pin mode 1, the wake condition is the pin at level 1.
- R5: With pin mode 2, the wake condition is the pin at level 0.
- R6: With pin mode 3, the wake condition is the pin differing from the level it had in the last ST_ON cycle. If the pin returns to that level before the count completes, the count restarts.
- R7: A pin wake is taken on the (N+1)th consecutive clock edge at which the condition holds in ST_OFF. With N=0, the wake is taken on the first such edge.
- R8: Pin modes 0 and 4..7 never wake from the pin, whatever it does.
- R9: In ST_OFF, `timer_req` wakes on the next edge only when mode bit 16 is 1, and `rtc_req` only when mode bit 17 is 1. A disabled request leaves `pwr_en` low.
- R10: A wake sets status bit 0 for the pin, bit 16 for the timer and bit 17 for the clock; sources active on the same edge all set. Reading offset 0x8 returns the flags and clears them on that clock edge.
- R11: In ST_ON, wake conditions are ignored and set no status bit. In ST_OFF, a further shutdown command leaves the controller off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high |
| wake_pin | input | 1 | External wake-up input (synchronous to clk) |
| timer_req | input | 1 | Wake request from the real-time timer |
| rtc_req | input | 1 | Wake request from the real-time clock |
| pwr_en | output | 1 | System power enable, high when powered |

## Verification
The bench counts edges exactly at the debounce boundary. A debounce that is off by one turns power on one cycle early or late, and the check fails in that cycle. In any-level mode the bench toggles the pin away and back before the count completes. A counter that fails to restart, or a reference level taken at the wrong time, then wakes the system spuriously. Wrong password keys, shutdown commands repeated while off, and wake requests made while already on all have to leave the output and the status word unchanged. Status reads are repeated to show that a read clears the flags and that a second read returns zero.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;
    typedef enum logic {ST_ON = 1'b0, ST_OFF = 1'b1} pwr_state_e;

    // Register byte offsets
    localparam int OFS_CTRL = 'h0;
    localparam int OFS_MODE = 'h4;
    localparam int OFS_STAT = 'h8;

    // Shutdown password carried in wdata[31:24]
    localparam logic [7:0] SHDN_KEY = 8'hA5;

    // Pin mode encodings
    localparam logic [2:0] PIN_HIGH = 3'd1;
    localparam logic [2:0] PIN_LOW  = 3'd2;
    localparam logic [2:0] PIN_ANY  = 3'd3;

    // Mode field positions
    localparam int MODE_CNT_LSB = 4;
    localparam int MODE_TMR_BIT = 16;
    localparam int MODE_RTC_BIT = 17;

    // Wake sources: index 0 pin, 1 timer, 2 clock; status bit of each
    localparam int NSRC = 3;
    localparam int SRC_POS [NSRC] = '{0, 16, 17};
endpackage

// File: rtl/wake_debounce.sv
module wake_debounce
    import pwr_sleep_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic [2:0]       pin_mode,
    input  logic [CNT_W-1:0] limit,
    input  logic             pin,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_q;
    logic             ref_q;
    logic             cond;

    always_comb begin
        unique case (pin_mode)
            PIN_HIGH: cond = pin;
            PIN_LOW:  cond = !pin;
            PIN_ANY:  cond = pin ^ ref_q;
            default:  cond = 1'b0;
        endcase
    end

    // The reference level follows the pin while powered and freezes once off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ref_q <= 1'b0;
        end else if (!armed) begin
            cnt_q <= '0;
            ref_q <= pin;
        end else if (!cond) begin
            cnt_q <= '0;
        end else if (cnt_q < limit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = armed && cond && (cnt_q >= limit);
endmodule

// File: rtl/sleep_regs.sv
module sleep_regs
    import pwr_sleep_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   src_set,
    output logic [DATA_W-1:0] rdata,
    output logic [2:0]        pin_mode,
    output logic [CNT_W-1:0]  pin_limit,
    output logic              tmr_en,
    output logic              rtc_en,
    output logic [DATA_W-1:0] stat_word
);
    localparam logic [DATA_W-1:0] MODE_MASK =
        DATA_W'(3'b111) | (DATA_W'({CNT_W{1'b1}}) << MODE_CNT_LSB) |
        (DATA_W'(1) << MODE_TMR_BIT) | (DATA_W'(1) << MODE_RTC_BIT);

    logic [DATA_W-1:0] mode_q;
    logic [NSRC-1:0]   stat_q;
    logic              stat_rd;

    assign stat_rd = rd_en && (addr == ADDR_W'(OFS_STAT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= '0;
        else if (wr_en && addr == ADDR_W'(OFS_MODE))
            mode_q <= wdata & MODE_MASK;
    end

    // A new wake wins over a clearing read in the same cycle
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stat_q[i] <= 1'b0;
            else if (src_set[i])
                stat_q[i] <= 1'b1;
            else if (stat_rd)
                stat_q[i] <= 1'b0;
        end
    end

    always_comb begin
        stat_word = '0;
        for (int i = 0; i < NSRC; i++)
            stat_word[SRC_POS[i]] = stat_q[i];
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == ADDR_W'(OFS_MODE))
                rdata = mode_q;
            else if (addr == ADDR_W'(OFS_STAT))
                rdata = stat_word;
        end
    end

    assign pin_mode  = mode_q[2:0];
    assign pin_limit = mode_q[MODE_CNT_LSB +: CNT_W];
    assign tmr_en    = mode_q[MODE_TMR_BIT];
    assign rtc_en    = mode_q[MODE_RTC_BIT];
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
    import pwr_sleep_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shutdown_cmd,
    input  logic            pin_hit,
    input  logic            tmr_wake,
    input  logic            rtc_wake,
    output logic            pwr_en,
    output logic            off,
    output logic [NSRC-1:0] src_set
);
    pwr_state_e state_q, state_d;
    logic       any_wake;

    assign any_wake = pin_hit || tmr_wake || rtc_wake;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ON:  if (shutdown_cmd) state_d = ST_OFF;   // T_SHUTDOWN
            ST_OFF: if (any_wake)     state_d = ST_ON;    // T_WAKE
            default: state_d = ST_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ON;
        else        state_q <= state_d;
    end

    always_comb begin
        pwr_en  = 1'b1;
        off     = 1'b0;
        src_set = '0;
        unique case (state_q)
            ST_ON: ;
            ST_OFF: begin
                pwr_en  = 1'b0;
                off     = 1'b1;
                src_set = {rtc_wake, tmr_wake, pin_hit};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              wake_pin,
    input  logic              timer_req,
    input  logic              rtc_req,
    output logic              pwr_en
);
    logic [2:0]        pin_mode;
    logic [CNT_W-1:0]  pin_limit;
    logic              tmr_en, rtc_en;
    logic [DATA_W-1:0] stat_word;
    logic [NSRC-1:0]   src_set;
    logic              off, pin_hit, shutdown_cmd;

    assign shutdown_cmd = wr_en && (addr == ADDR_W'(OFS_CTRL)) && wdata[0] &&
                          (wdata[DATA_W-1 -: 8] == SHDN_KEY);

    sleep_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .src_set(src_set), .rdata(rdata), .pin_mode(pin_mode),
        .pin_limit(pin_limit), .tmr_en(tmr_en), .rtc_en(rtc_en),
        .stat_word(stat_word)
    );

    wake_debounce #(.CNT_W(CNT_W)) u_deb (
        .clk(clk), .rst_n(rst_n), .armed(off), .pin_mode(pin_mode),
        .limit(pin_limit), .pin(wake_pin), .hit(pin_hit)
    );

    sleep_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .shutdown_cmd(shutdown_cmd),
        .pin_hit(pin_hit), .tmr_wake(timer_req && tmr_en),
        .rtc_wake(rtc_req && rtc_en), .pwr_en(pwr_en), .off(off),
        .src_set(src_set)
    );
endmodule

// File: rtl/pwr_sleep_chk.sv
module pwr_sleep_chk
    import pwr_sleep_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              timer_req,
    input logic              rtc_req,
    input logic              pwr_en,
    input logic [2:0]        pin_mode,
    input logic              tmr_en,
    input logic              rtc_en,
    input logic [DATA_W-1:0] stat_word
);
    logic ctrl_wr, good_cmd, stat_rd;
    assign ctrl_wr  = wr_en && addr == ADDR_W'(OFS_CTRL);
    assign good_cmd = ctrl_wr && wdata[0] && wdata[DATA_W-1 -: 8] == SHDN_KEY;
    assign stat_rd  = rd_en && addr == ADDR_W'(OFS_STAT);

    // R2
    key_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_en && good_cmd |=> !pwr_en);

    // R2
    bad_key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_en && !good_cmd |=> pwr_en);

    // R8
    pin_none_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en && (pin_mode == 3'd0 || pin_mode > 3'd3) &&
        !(timer_req && tmr_en) && !(rtc_req && rtc_en) |=> !pwr_en);

    // R9
    timer_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en && timer_req && tmr_en |=> pwr_en && stat_word[16]);

    // R10
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_en && stat_rd |=> stat_word == '0);

    // R11
    on_status_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_en && !ctrl_wr && !stat_rd |=> $stable(stat_word));
endmodule

bind pwr_sleep_ctrl pwr_sleep_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .timer_req(timer_req), .rtc_req(rtc_req), .pwr_en(pwr_en),
    .pin_mode(pin_mode), .tmr_en(tmr_en), .rtc_en(rtc_en),
    .stat_word(stat_word)
);

// File: tb/sim_pwr_sleep_ctrl.sv
module sim_pwr_sleep_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wake_pin = 1'b0, timer_req = 1'b0, rtc_req = 1'b0;
    logic        pwr_en;
    int          total = 0, bad = 0;

    always #10 clk = ~clk;

    pwr_sleep_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .wake_pin(wake_pin),
        .timer_req(timer_req), .rtc_req(rtc_req), .pwr_en(pwr_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick(1);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        #2 d = rdata;
        tick(1);
        rd_en = 1'b0;
    endtask

    task automatic go_off(input string tag);
        bus_wr(4'h0, 32'hA500_0001);
        check(tag, {31'd0, pwr_en}, 32'd0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 pwr_en", {31'd0, pwr_en}, 32'd1);
        bus_rd(4'h4, d); check("R1 mode", d, 32'd0);
        bus_rd(4'h8, d); check("R1 status", d, 32'd0);
    endtask

    task automatic t_mode_rw;
        logic [31:0] d;
        bus_wr(4'h4, 32'hFFFF_FFFF);
        bus_rd(4'h4, d); check("R3 mode mask", d, 32'h0003_00F7);
        bus_wr(4'h4, 32'h0);
    endtask

    task automatic t_key;
        logic [31:0] d;
        bus_wr(4'h0, 32'h5A00_0001);
        check("R2 wrong key", {31'd0, pwr_en}, 32'd1);
        bus_wr(4'h0, 32'hA500_0000);
        check("R2 no cmd bit", {31'd0, pwr_en}, 32'd1);
        bus_rd(4'h0, d); check("R2 ctrl reads 0", d, 32'd0);
        go_off("R2 shutdown");
        // R8: mode 0 and mode 4 ignore the pin
        wake_pin = 1'b1; tick(3); wake_pin = 1'b0; tick(3);
        check("R8 mode0 pin", {31'd0, pwr_en}, 32'd0);
        bus_wr(4'h4, 32'h4);
        wake_pin = 1'b1; tick(4);
        check("R8 mode4 pin", {31'd0, pwr_en}, 32'd0);
        wake_pin = 1'b0; tick(4);
        check("R8 mode4 pin low", {31'd0, pwr_en}, 32'd0);
        bus_wr(4'h4, 32'h0);
        // R11: second shutdown while off
        bus_wr(4'h0, 32'hA500_0001);
        check("R11 shutdown while off", {31'd0, pwr_en}, 32'd0);
        // R9: disabled timer request
        timer_req = 1'b1; tick(3);
        check("R9 timer disabled", {31'd0, pwr_en}, 32'd0);
        bus_wr(4'h4, 32'h0001_0000);
        check("R9 enable edge", {31'd0, pwr_en}, 32'd0);
        tick(1);
        check("R9 timer wake", {31'd0, pwr_en}, 32'd1);
        timer_req = 1'b0;
        bus_rd(4'h8, d); check("R10 timer flag", d, 32'h0001_0000);
        bus_rd(4'h8, d); check("R10 cleared", d, 32'd0);
    endtask

    task automatic t_high;
        logic [31:0] d;
        bus_wr(4'h4, 32'h31);
        wake_pin = 1'b0;
        go_off("R4 off");
        wake_pin = 1'b1; tick(3);
        check("R7 high N=3 early", {31'd0, pwr_en}, 32'd0);
        tick(1);
        check("R4 high wake", {31'd0, pwr_en}, 32'd1);
        wake_pin = 1'b0;
        bus_rd(4'h8, d); check("R10 pin flag", d, 32'h1);
    endtask

    task automatic t_low;
        logic [31:0] d;
        bus_wr(4'h4, 32'h2);
        wake_pin = 1'b1;
        go_off("R5 off");
        tick(3);
        check("R5 high level no wake", {31'd0, pwr_en}, 32'd0);
        wake_pin = 1'b0; tick(1);
        check("R7 N=0 first edge", {31'd0, pwr_en}, 32'd1);
        bus_rd(4'h8, d); check("R5 pin flag", d, 32'h1);
    endtask

    task automatic t_any;
        logic [31:0] d;
        bus_wr(4'h4, 32'h23);
        wake_pin = 1'b0;
        go_off("R6 off");
        wake_pin = 1'b1; tick(1);
        wake_pin = 1'b0; tick(1);
        check("R6 toggle back", {31'd0, pwr_en}, 32'd0);
        tick(3);
        check("R6 ref level idle", {31'd0, pwr_en}, 32'd0);
        wake_pin = 1'b1; tick(2);
        check("R6 restart early", {31'd0, pwr_en}, 32'd0);
        tick(1);
        check("R6 any wake", {31'd0, pwr_en}, 32'd1);
        bus_rd(4'h8, d); check("R6 pin flag", d, 32'h1);
        // reference taken high: falling edge wakes
        go_off("R6 off2");
        tick(4);
        check("R6 high ref idle", {31'd0, pwr_en}, 32'd0);
        wake_pin = 1'b0; tick(2);
        check("R6 fall early", {31'd0, pwr_en}, 32'd0);
        tick(1);
        check("R6 fall wake", {31'd0, pwr_en}, 32'd1);
        bus_rd(4'h8, d);
    endtask

    task automatic t_on_ignore;
        logic [31:0] d;
        bus_wr(4'h4, 32'h0003_0001);
        wake_pin = 1'b1; timer_req = 1'b1; rtc_req = 1'b1; tick(4);
        check("R11 on stays", {31'd0, pwr_en}, 32'd1);
        bus_rd(4'h8, d); check("R11 no flags when on", d, 32'd0);
        wake_pin = 1'b0; timer_req = 1'b0; rtc_req = 1'b0;
    endtask

    task automatic t_rtc;
        logic [31:0] d;
        bus_wr(4'h4, 32'h0002_0000);
        go_off("R9 rtc off");
        timer_req = 1'b1; tick(2);
        check("R9 timer disabled 2", {31'd0, pwr_en}, 32'd0);
        timer_req = 1'b0;
        rtc_req = 1'b1; tick(1); rtc_req = 1'b0;
        check("R9 rtc wake", {31'd0, pwr_en}, 32'd1);
        bus_rd(4'h8, d); check("R10 rtc flag", d, 32'h0002_0000);
        bus_wr(4'h4, 32'h0003_0001);
        go_off("R10 both off");
        timer_req = 1'b1; rtc_req = 1'b1; wake_pin = 1'b1; tick(1);
        timer_req = 1'b0; rtc_req = 1'b0; wake_pin = 1'b0;
        check("R10 joint wake", {31'd0, pwr_en}, 32'd1);
        bus_rd(4'h8, d); check("R10 three flags", d, 32'h0003_0001);
    endtask

    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_mode_rw();
        t_key();
        t_high();
        t_low();
        t_any();
        t_on_ignore();
        t_rtc();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule